// File: doc/BRIEF.md
# Three-Phase Latch-Free Pipeline Controller

This block is a cycle-level model of a latch-free pipeline in which every stage is steered by two separate controls, one that discharges (precharges) the stage and one that lets it compute (evaluates). When neither control is active, the stage is in a third state called isolate. In isolate the stage keeps its result and does not respond to anything on its input. Because an isolated stage holds a complete item without an empty stage next to it, every stage in the chain can hold its own item at the same time.

Data travels single-rail. A request travels alongside the data, and a matched delay of a configurable number of clock steps stands in for completion detection. A stage reports done only once that delay has run out after it began to evaluate.

A stage keeps a small flag recording that its successor has finished evaluating the stage's current item. The stage precharges only when that flag is set. Once it has precharged, the stage runs its next full cycle without waiting for anything else downstream.

The source and the sink connect through valid/ready handshakes. A transfer takes place on a clock edge at which both valid and ready are high.

Top module: `hc3_pipe`

## Requirements
- R1: After reset every stage is precharged, so `src_ready` is 1 and `snk_valid` is 0.
- R2: Each stage steps through evaluate, then isolate, then precharge, and then evaluate again, in that order only. It never skips a phase and never goes backwards.
- R3: A stage stays in evaluate for exactly DELAY clock cycles before it reports done. With the sink ready, an item accepted on clock edge E0 raises `snk_valid` after edge E0 + STAGES*(DELAY+1) - 1 and not before that edge.
- R4: While the sink holds `snk_ready` low, `snk_valid` stays high and `snk_data` does not change, even when `src_valid` and `src_data` change.
- R5: A stage does not precharge while its successor is still evaluating the item taken from it. It precharges only after the successor has finished that item.
- R6: With the sink stalled, the pipeline accepts exactly STAGES items and then holds `src_ready` low. A stage that has just accepted an item holds `src_ready` low on the following cycle.
- R7: Items leave in the order they were accepted, and none is lost or duplicated, under any pattern of source and sink stalls.
- R8: With the source always valid and the sink always ready, deliveries occur exactly once every 2*DELAY+4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source offers an item |
| src_ready | output | 1 | First stage is precharged and can accept an item |
| src_data | input | DATA_W | Item offered by the source |
| snk_valid | output | 1 | Last stage holds an item the sink has not yet taken |
| snk_ready | input | 1 | Sink takes the item offered |
| snk_data | output | DATA_W | Item held by the last stage |

## Verification
The first output from an empty pipeline is due exactly STAGES*(DELAY+1)-1 edges after the edge that accepted the item. The bench counts edges from that acceptance and samples `snk_valid` one cycle before the due edge and at the due edge itself. In steady flow a delivery is due every 2*DELAY+4 cycles. The bench records the cycle number of each delivery and compares the gaps between later deliveries with that figure. Every handshake is judged half a cycle before the edge that commits it, and the scoreboard receives an item only when the bench observes acceptance. Hold behaviour is checked on every stalled cycle by comparing against the value seen one cycle earlier.

// File: rtl/hc3_pkg.sv
package hc3_pkg;

   // Phases of one stage; legal order is PRE -> EVAL -> ISO -> PRE.
   typedef enum logic [1:0] {
      PH_PRE  = 2'd0,
      PH_EVAL = 2'd1,
      PH_ISO  = 2'd2
   } hc3_phase_e;

   function automatic int unsigned hc3_cnt_w(input int unsigned delay);
      return (delay > 1) ? $clog2(delay) : 1;
   endfunction

endpackage

// File: rtl/hc3_match_delay.sv
// Matched-delay model: counts clock steps from the start of evaluation.
module hc3_match_delay #(
   parameter int unsigned DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = hc3_pkg::hc3_cnt_w(DELAY);
   localparam logic [CW-1:0] LAST_STEP = CW'(DELAY - 1);

   logic [CW-1:0] step_q;

   if (DELAY < 1) begin : g_bad_delay
      $error("hc3_match_delay: DELAY must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (start) begin
         step_q <= '0;
      end else if (run && (step_q != LAST_STEP)) begin
         step_q <= step_q + 1'b1;
      end
   end

   assign expired = run && (step_q == LAST_STEP);

   a_r3_step_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (run && !expired) |=> (step_q != '0) || start);

endmodule

// File: rtl/hc3_stage_ctrl.sv
// Per-stage controller: precharge/evaluate controls, done, absorbed flag.
module hc3_stage_ctrl
   import hc3_pkg::*;
#(
   parameter int unsigned DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_offer,    // predecessor holds an item not yet taken
   input  logic succ_take,   // successor takes this stage's item now
   input  logic succ_done,   // successor has finished evaluating
   output logic take,        // this stage captures from its input now
   output logic pc,          // precharge control
   output logic ev,          // evaluate control
   output logic done,        // matched-delay request/done
   output logic out_offer    // item available to successor
);
   hc3_phase_e ph_q, ph_d;
   logic       fwd_q;        // successor has taken the current item
   logic       ok2pc_q;      // successor has finished the current item
   logic       dly_exp;
   logic       to_pre;

   hc3_match_delay #(.DELAY(DELAY)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (take),
      .run     (ph_q == PH_EVAL),
      .expired (dly_exp)
   );

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_PRE:  if (in_offer) ph_d = PH_EVAL;
         PH_EVAL: if (dly_exp)  ph_d = PH_ISO;
         PH_ISO:  if (ok2pc_q)  ph_d = PH_PRE;
         default: ph_d = PH_PRE;
      endcase
   end

   assign take      = (ph_q == PH_PRE) && in_offer;
   assign to_pre    = (ph_q == PH_ISO) && ok2pc_q;
   assign pc        = (ph_q == PH_PRE);
   assign ev        = (ph_q == PH_EVAL);
   assign done      = (ph_q == PH_ISO);
   assign out_offer = done && !fwd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_PRE;
         fwd_q   <= 1'b0;
         ok2pc_q <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (to_pre)          fwd_q <= 1'b0;
         else if (succ_take)  fwd_q <= 1'b1;
         if (to_pre)                  ok2pc_q <= 1'b0;
         else if (fwd_q && succ_done) ok2pc_q <= 1'b1;
      end
   end

   // R2: phase order
   a_r2_from_pre : assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_PRE) |=> (ph_q == PH_PRE) || (ph_q == PH_EVAL));
   a_r2_from_eval : assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_EVAL) |=> (ph_q == PH_EVAL) || (ph_q == PH_ISO));
   a_r2_from_iso : assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_ISO) |=> (ph_q == PH_ISO) || (ph_q == PH_PRE));
   // R4: an offered item stays offered until the successor takes it
   a_r4_offer_held : assert property (@(posedge clk) disable iff (!rst_n)
      (out_offer && !succ_take) |=> out_offer);
   // R7: successor only takes what is offered
   a_r7_take_offered : assert property (@(posedge clk) disable iff (!rst_n)
      succ_take |-> out_offer);

endmodule

// File: rtl/hc3_stage_store.sv
// Stage storage: loads at the start of evaluation, otherwise holds.
module hc3_stage_store #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clr,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d_in;
      else if (clr)  q <= '0;
   end

   // R4: without load or clear the stored value never moves
   a_r4_store_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clr) |=> $stable(q));

endmodule

// File: rtl/hc3_pipe.sv
// Chain of three-phase stages with source and sink handshakes.
module hc3_pipe #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned STAGES      = 4,
   parameter int unsigned DELAY       = 2,
   parameter bit          CLEAR_ON_PC = 1'b1  // model discharge of stage output
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [DATA_W-1:0] src_data,
   output logic              snk_valid,
   input  logic              snk_ready,
   output logic [DATA_W-1:0] snk_data
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 1) begin : g_bad_stages
      $error("hc3_pipe: STAGES must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("hc3_pipe: DATA_W must be at least 1");
   end
   if (DELAY < 1) begin : g_bad_delay
      $error("hc3_pipe: DELAY must be at least 1");
   end

   logic              st_take  [STAGES];
   logic              st_pc    [STAGES];
   logic              st_ev    [STAGES];
   logic              st_done  [STAGES];
   logic              st_offer [STAGES];
   logic              st_clr   [STAGES];
   logic [DATA_W-1:0] st_q     [STAGES];
   logic              snk_take;

   assign snk_take = snk_valid && snk_ready;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic              in_offer;
      logic [DATA_W-1:0] in_data;
      logic              succ_take;
      logic              succ_done;

      if (i == 0) begin : g_head
         assign in_offer = src_valid;
         assign in_data  = src_data;
      end else begin : g_mid_in
         assign in_offer = st_offer[i-1];
         assign in_data  = st_q[i-1];
      end

      if (i == LAST) begin : g_tail
         assign succ_take = snk_take;
         assign succ_done = 1'b1;
      end else begin : g_mid_out
         assign succ_take = st_take[i+1];
         assign succ_done = st_done[i+1];
      end

      if (CLEAR_ON_PC) begin : g_clr_pc
         assign st_clr[i] = st_pc[i];
      end else begin : g_keep
         assign st_clr[i] = 1'b0;
      end

      hc3_stage_ctrl #(.DELAY(DELAY)) u_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_offer  (in_offer),
         .succ_take (succ_take),
         .succ_done (succ_done),
         .take      (st_take[i]),
         .pc        (st_pc[i]),
         .ev        (st_ev[i]),
         .done      (st_done[i]),
         .out_offer (st_offer[i])
      );

      hc3_stage_store #(.DATA_W(DATA_W)) u_store (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (st_take[i]),
         .clr   (st_clr[i]),
         .d_in  (in_data),
         .q     (st_q[i])
      );

      // R3: a stage that has just captured is not yet done
      a_r3_no_early_done : assert property (@(posedge clk) disable iff (!rst_n)
         st_take[i] |=> !st_done[i] && st_ev[i]);

      if (i < LAST) begin : g_link_chk
         // R5: isolated stage stays out of precharge while successor evaluates
         a_r5_wait_succ : assert property (@(posedge clk) disable iff (!rst_n)
            (!st_pc[i] && !st_ev[i] && st_ev[i+1]) |=> !st_pc[i]);
      end
   end

   assign src_ready = st_pc[0];
   assign snk_valid = st_offer[LAST];
   assign snk_data  = st_q[LAST];

   // R4: sink stall holds the offered item
   a_r4_snk_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && !snk_ready) |=> snk_valid && $stable(snk_data) && !st_pc[LAST]);
   // R6: an accepted item closes the input for the next cycle
   a_r6_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_ready) |=> !src_ready);

endmodule

// File: tb/tb_hc3_pipe.sv
module tb_hc3_pipe;
   localparam int unsigned W      = 8;
   localparam int unsigned S      = 4;
   localparam int unsigned D      = 2;
   localparam int unsigned LAT    = S * (D + 1) - 1;
   localparam int unsigned PERIOD = 2 * D + 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_valid = 1'b0;
   logic         src_ready;
   logic [W-1:0] src_data = '0;
   logic         snk_valid;
   logic         snk_ready = 1'b0;
   logic [W-1:0] snk_data;

   int           n_tests = 0;
   int           n_fail  = 0;
   int           cyc     = 0;
   int           n_deliv = 0;
   int           last_dlv_cyc = 0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] seq_val = 8'h10;
   logic         prev_stall = 1'b0;
   logic [W-1:0] prev_data  = '0;

   always #4 clk = ~clk;   // 125 MHz

   hc3_pipe #(.DATA_W(W), .STAGES(S), .DELAY(D)) dut (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Drive inputs for one cycle; judge the handshakes that the next edge commits.
   task automatic step(input logic v, input logic [W-1:0] d, input logic r,
                       output logic acc, output logic dlv);
      @(negedge clk);
      src_valid = v;
      src_data  = d;
      snk_ready = r;
      #1;
      // R4: a stalled sink sees the same item on the next cycle
      if (prev_stall) begin
         chk(snk_valid == 1'b1, "R4 valid held", int'(snk_valid), 1);
         chk(snk_data == prev_data, "R4 data held", int'(snk_data), int'(prev_data));
      end
      prev_stall = snk_valid && !r;
      prev_data  = snk_data;
      acc = v && src_ready;
      if (acc) exp_q.push_back(d);
      dlv = snk_valid && r;
      if (dlv) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected item", int'(snk_data), -1);
         end else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(snk_data == e, "R7 order", int'(snk_data), int'(e));
         end
         n_deliv++;
         last_dlv_cyc = cyc;
      end
   endtask

   task automatic drain();
      logic a, b;
      for (int k = 0; k < 400 && exp_q.size() != 0; k++) step(1'b0, '0, 1'b1, a, b);
      for (int k = 0; k < 3 * PERIOD; k++) step(1'b0, '0, 1'b1, a, b);
      chk(exp_q.size() == 0, "R7 drained", exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic a, b;
      int accepted;
      int t_prev;
      int gaps_ok;
      logic [W-1:0] held;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(src_ready == 1'b1, "R1 src_ready", int'(src_ready), 1);
      chk(snk_valid == 1'b0, "R1 snk_valid", int'(snk_valid), 0);

      // R3: first-item latency from an empty pipeline
      a = 1'b0;
      while (!a) step(1'b1, 8'hA5, 1'b1, a, b);
      for (int k = 0; k <= LAT; k++) begin
         step(1'b0, '0, 1'b1, a, b);
         if (k == LAT - 1) chk(snk_valid == 1'b0, "R3 not before due edge", int'(snk_valid), 0);
         if (k == LAT)     chk(snk_valid == 1'b1, "R3 at due edge", int'(snk_valid), 1);
      end
      drain();

      // R6: fill with the sink stalled
      accepted = 0;
      for (int k = 0; k < 80; k++) begin
         step(1'b1, seq_val, 1'b0, a, b);
         if (a) begin
            accepted++;
            seq_val++;
         end
      end
      chk(accepted == S, "R6 capacity", accepted, S);
      chk(src_ready == 1'b0, "R6 input closed when full", int'(src_ready), 0);

      // R4: input changes ignored while stages isolate
      held = snk_data;
      for (int k = 0; k < 12; k++) step(k[0], W'(k * 37), 1'b0, a, b);
      chk(snk_data == held, "R4 isolate ignores input", int'(snk_data), int'(held));
      chk(exp_q.size() == S, "R6 distinct items held", exp_q.size(), S);
      drain();

      // R8: steady-state delivery interval
      n_deliv = 0;
      t_prev  = 0;
      gaps_ok = 0;
      for (int k = 0; k < 14 * PERIOD; k++) begin
         step(1'b1, seq_val, 1'b1, a, b);
         if (a) seq_val++;
         if (b) begin
            if (n_deliv >= 4 && n_deliv <= 9) begin
               chk(last_dlv_cyc - t_prev == PERIOD, "R8 interval",
                   last_dlv_cyc - t_prev, PERIOD);
               gaps_ok++;
            end
            t_prev = last_dlv_cyc;
         end
      end
      chk(gaps_ok == 6, "R8 enough deliveries", gaps_ok, 6);
      drain();

      // R7: random source and sink stalls
      n_deliv  = 0;
      accepted = 0;
      while (accepted < 300) begin
         step(($urandom_range(0, 9) < 7), seq_val, ($urandom_range(0, 9) < 6), a, b);
         if (a) begin
            accepted++;
            seq_val++;
         end
      end
      drain();
      chk(n_deliv == 300, "R7 lossless count", n_deliv, 300);

      // R1/R6: pipeline idle and open again
      chk(src_ready == 1'b1, "R6 open when empty", int'(src_ready), 1);
      chk(snk_valid == 1'b0, "R1 idle output", int'(snk_valid), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule